// File: doc/BRIEF.md
# Address-Encoded Video Fill Write Path

This cartridge-side block lets one CPU store instruction place a constant byte into graphics RAM. The byte does not travel on the CPU data bus. It is carried in CPU address bits 11..4 of a mirror of the video data-port register, in the range 0x2000–0x3FFF with low nibble 7. The block watches CPU writes to those mirrors and captures the encoded byte as a pending fill. When the video processor performs its next memory write, the block steers the held byte into graphics RAM. That write completes the fill, so one fill byte costs a single four-cycle absolute store on the CPU side.

The video write address chooses the target of the fill. Writes to 0x2000–0x2FFF go to the high name-table area in the lowest 2 KB of graphics RAM, which uses the same mirroring as the console's internal name-table memory. The internal name table is still enabled in this case and takes the normal data byte. Writes to 0x3000–0x3EFF go to the selected sprite bank, and the internal name table is disabled. A control input can block the graphics RAM part of name-table fills. Ordinary data-port traffic at 0x1000–0x1FFF reads and writes the selected sprite bank.

Top module: `fillwr_top`

## Requirements
- R1: After reset no fill is pending: a video write to 0x2000–0x2FFF then produces no graphics RAM write. The internal name-table enable `ntram_ce` is low whenever no video access is in progress.
- R2: A CPU write whose address has bits 15..13 = 001, bits 3..0 = 0111 and bits 11..4 ≠ 0 captures bits 11..4 as a pending fill byte. The next video write to 0x2000–0x2FFF writes that byte to graphics RAM address {zeros, m, ppu_addr[9:0]}, where m is ppu_addr[11] when `nt_mirror_h`=1 and ppu_addr[10] otherwise. `ntram_ce` is high during that write.
- R3: With a fill pending, a video write to 0x3000–0x3EFF writes the pending byte to graphics RAM address {spr_bank, ppu_addr[11:0]}, and `ntram_ce` is low.
- R4: With `fill_gram_en`=0, a pending fill to 0x2000–0x2FFF produces no graphics RAM write. `ntram_ce` stays high, and the pending fill is consumed.
- R5: A CPU write whose encoded byte is 0x00 (for example 0x2007 or 0x3007) captures nothing. The following video write behaves as an ordinary access.
- R6: Every video write clears the pending fill, whatever its address. A later video write to 0x2000–0x3EFF is then an ordinary name-table write: no graphics RAM write, and `ntram_ce` is high.
- R7: Video accesses to 0x1000–0x1FFF map to graphics RAM address {spr_bank, ppu_addr[11:0]}. `gram_we` follows `ppu_wr` with data `ppu_wdata`, and `gram_oe` follows `ppu_rd`. A pending fill is not used on such a write.
- R8: When a CPU capture and a video write fall in the same cycle, the video write uses the byte held before that cycle. The newly captured byte is pending afterwards.
- R9: CPU writes whose low nibble is not 7, or whose address lies outside 0x2000–0x3FFF, leave the pending state and the pending byte unchanged.
- R10: Video accesses to 0x0000–0x0FFF and to 0x3F00–0x3FFF enable neither graphics RAM nor the internal name table.
- R11: A second capture before any video write replaces the pending byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-synchronous clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_addr | input | 16 | CPU address |
| ppu_wr | input | 1 | Video memory write strobe |
| ppu_rd | input | 1 | Video memory read strobe |
| ppu_addr | input | 14 | Video memory address |
| ppu_wdata | input | 8 | Video write data for ordinary writes |
| spr_bank | input | 7 | Selected 4 KB sprite bank |
| nt_mirror_h | input | 1 | 1: name-table mirroring selects on address bit 11; 0: on bit 10 |
| fill_gram_en | input | 1 | Lets name-table fills reach graphics RAM |
| gram_addr | output | 19 | Graphics RAM address |
| gram_wdata | output | 8 | Graphics RAM write data |
| gram_we | output | 1 | Graphics RAM write enable |
| gram_oe | output | 1 | Graphics RAM output enable |
| ntram_ce | output | 1 | Internal name-table memory enable |

## Verification
Capture of a new fill byte and consumption of the held one can happen in the same clock: a CPU store to a mirror and a video write both arrive. The bench arranges this by holding one byte, then asserting both strobes together with a second encoded address. The graphics RAM data seen during that cycle must be the older byte. A following video write must carry the newer byte, which shows that the capture took priority over the clear.

// File: rtl/fillwr_pkg.sv
package fillwr_pkg;
  localparam int CPU_AW = 16;
  localparam int PPU_AW = 14;
  localparam int FILL_W = 8;

  typedef enum logic [2:0] {
    RG_PLAY,   // 0x0000-0x0FFF playfield patterns
    RG_SPR,    // 0x1000-0x1FFF sprite bank window
    RG_NTHI,   // 0x2000-0x2FFF name tables
    RG_NTMIR,  // 0x3000-0x3EFF name-table mirror
    RG_PAL     // 0x3F00-0x3FFF palette
  } vregion_e;

  function automatic vregion_e region_of(input logic [PPU_AW-1:0] a);
    case (a[13:12])
      2'b00: return RG_PLAY;
      2'b01: return RG_SPR;
      2'b10: return RG_NTHI;
      default: return (a[11:8] == 4'hF) ? RG_PAL : RG_NTMIR;
    endcase
  endfunction

  function automatic logic [FILL_W-1:0] fill_byte(input logic [CPU_AW-1:0] a);
    return a[11:4];
  endfunction

  function automatic logic is_capture(input logic [CPU_AW-1:0] a);
    return (a[15:13] == 3'b001) && (a[3:0] == 4'h7) && (fill_byte(a) != '0);
  endfunction

  function automatic logic nt_sel_bit(input logic [PPU_AW-1:0] a, input logic mir_h);
    return mir_h ? a[11] : a[10];
  endfunction
endpackage

// File: rtl/fillwr_capture.sv
module fillwr_capture
  import fillwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              ppu_wr,
  output logic              pend_q,
  output logic [FILL_W-1:0] pend_val
);
  logic cap_hit;
  assign cap_hit = cpu_wr && is_capture(cpu_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_val <= '0;
    end else if (cap_hit) begin
      pend_q   <= 1'b1;
      pend_val <= fill_byte(cpu_addr);
    end else if (ppu_wr) begin
      pend_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/fillwr_steer.sv
module fillwr_steer
  import fillwr_pkg::*;
#(
  parameter int BANK_W = 7,
  parameter int PAGE_W = 12,
  localparam int GAW   = BANK_W + PAGE_W
) (
  input  logic              ppu_wr,
  input  logic              ppu_rd,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic [FILL_W-1:0] ppu_wdata,
  input  logic [BANK_W-1:0] spr_bank,
  input  logic              nt_mirror_h,
  input  logic              fill_gram_en,
  input  logic              pend_q,
  input  logic [FILL_W-1:0] pend_val,
  output logic [GAW-1:0]    gram_addr,
  output logic [FILL_W-1:0] gram_wdata,
  output logic              gram_we,
  output logic              gram_oe,
  output logic              ntram_ce,
  output logic              fill_fire
);
  vregion_e         rg;
  logic [GAW-1:0]   spr_ga;
  logic [GAW-1:0]   nt_ga;
  logic             acc;

  assign rg     = region_of(ppu_addr);
  assign spr_ga = {spr_bank, ppu_addr[PAGE_W-1:0]};
  assign acc    = ppu_wr || ppu_rd;

  always_comb begin
    nt_ga     = '0;
    nt_ga[10] = nt_sel_bit(ppu_addr, nt_mirror_h);
    nt_ga[9:0] = ppu_addr[9:0];
  end

  always_comb begin
    gram_addr  = '0;
    gram_wdata = '0;
    gram_we    = 1'b0;
    gram_oe    = 1'b0;
    ntram_ce   = 1'b0;
    fill_fire  = 1'b0;
    case (rg)
      RG_SPR: begin
        gram_addr  = spr_ga;
        gram_wdata = ppu_wdata;
        gram_we    = ppu_wr;
        gram_oe    = ppu_rd;
      end
      RG_NTHI: begin
        ntram_ce = acc;
        if (ppu_wr && pend_q) begin
          fill_fire  = 1'b1;
          gram_addr  = nt_ga;
          gram_wdata = pend_val;
          gram_we    = fill_gram_en;
        end
      end
      RG_NTMIR: begin
        if (ppu_wr && pend_q) begin
          fill_fire  = 1'b1;
          gram_addr  = spr_ga;
          gram_wdata = pend_val;
          gram_we    = 1'b1;
        end else begin
          ntram_ce = acc;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fillwr_top.sv
module fillwr_top
  import fillwr_pkg::*;
#(
  parameter int BANK_W = 7,
  parameter int PAGE_W = 12,
  localparam int GAW   = BANK_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [15:0]       cpu_addr,
  input  logic              ppu_wr,
  input  logic              ppu_rd,
  input  logic [13:0]       ppu_addr,
  input  logic [7:0]        ppu_wdata,
  input  logic [BANK_W-1:0] spr_bank,
  input  logic              nt_mirror_h,
  input  logic              fill_gram_en,
  output logic [GAW-1:0]    gram_addr,
  output logic [7:0]        gram_wdata,
  output logic              gram_we,
  output logic              gram_oe,
  output logic              ntram_ce
);
  logic              pend_q;
  logic [FILL_W-1:0] pend_val;
  logic              fill_fire;

  fillwr_capture u_cap (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .ppu_wr(ppu_wr), .pend_q(pend_q), .pend_val(pend_val)
  );

  fillwr_steer #(.BANK_W(BANK_W), .PAGE_W(PAGE_W)) u_steer (
    .ppu_wr(ppu_wr), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .ppu_wdata(ppu_wdata),
    .spr_bank(spr_bank), .nt_mirror_h(nt_mirror_h), .fill_gram_en(fill_gram_en),
    .pend_q(pend_q), .pend_val(pend_val),
    .gram_addr(gram_addr), .gram_wdata(gram_wdata), .gram_we(gram_we),
    .gram_oe(gram_oe), .ntram_ce(ntram_ce), .fill_fire(fill_fire)
  );
endmodule

// File: rtl/fillwr_chk.sv
module fillwr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_wr,
  input logic [15:0] cpu_addr,
  input logic        ppu_wr,
  input logic        ppu_rd,
  input logic [13:0] ppu_addr,
  input logic        fill_gram_en,
  input logic [7:0]  gram_wdata,
  input logic        gram_we,
  input logic        gram_oe,
  input logic        ntram_ce,
  input logic        pend_q,
  input logic [7:0]  pend_val,
  input logic        fill_fire
);
  logic cap_a;
  assign cap_a = cpu_wr && cpu_addr[15:13] == 3'b001 && cpu_addr[3:0] == 4'h7
                 && cpu_addr[11:4] != 8'h00;

  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_a |=> pend_q && pend_val == $past(cpu_addr[11:4]));

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_wr && !cap_a |=> !pend_q);

  p_spr_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && ppu_wr && ppu_addr[13:12] == 2'b11 && ppu_addr[11:8] != 4'hF
    |-> fill_fire && gram_we && !ntram_ce && gram_wdata == pend_val);

  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && ppu_wr && ppu_addr[13:12] == 2'b10 && !fill_gram_en
    |-> !gram_we && ntram_ce);

  p_idle_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q && ppu_addr[13] |-> !gram_we && !fill_fire);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_a && !ppu_wr |=> $stable(pend_q) && $stable(pend_val));

  p_port_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ppu_addr[13:12] == 2'b01 |-> gram_we == ppu_wr && gram_oe == ppu_rd);
endmodule

bind fillwr_top fillwr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
  .ppu_wr(ppu_wr), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr),
  .fill_gram_en(fill_gram_en), .gram_wdata(gram_wdata), .gram_we(gram_we),
  .gram_oe(gram_oe), .ntram_ce(ntram_ce), .pend_q(pend_q), .pend_val(pend_val),
  .fill_fire(fill_fire)
);

// File: tb/fillwr_tb.sv
module fillwr_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        ppu_wr = 1'b0;
  logic        ppu_rd = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [7:0]  ppu_wdata = '0;
  logic [6:0]  spr_bank = '0;
  logic        nt_mirror_h = 1'b0;
  logic        fill_gram_en = 1'b1;
  logic [18:0] gram_addr;
  logic [7:0]  gram_wdata;
  logic        gram_we, gram_oe, ntram_ce;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fillwr_top dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .ppu_wr(ppu_wr), .ppu_rd(ppu_rd), .ppu_addr(ppu_addr), .ppu_wdata(ppu_wdata),
    .spr_bank(spr_bank), .nt_mirror_h(nt_mirror_h), .fill_gram_en(fill_gram_en),
    .gram_addr(gram_addr), .gram_wdata(gram_wdata), .gram_we(gram_we),
    .gram_oe(gram_oe), .ntram_ce(ntram_ce)
  );

  // kind: 0 CPU write, 1 video write, 2 video read
  typedef struct packed {
    logic [1:0]  kind;
    logic [15:0] addr;
    logic [7:0]  wd;
    logic [6:0]  bank;
    logic        mir;
    logic        fen;
    logic        ewe;
    logic        eoe;
    logic        ece;
    logic [18:0] eaddr;
    logic [7:0]  edat;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 16'h2AB7, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd2},  // R2 capture AB
    '{2'd1, 16'h2C35, 8'h77, 7'h15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 19'h00435, 8'hAB, 4'd2},  // R2 NT fill
    '{2'd1, 16'h2C35, 8'h77, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 19'h0,     8'h00, 4'd6},  // R6 consumed
    '{2'd0, 16'h3FF7, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd3},  // R3 capture FF
    '{2'd1, 16'h3123, 8'h00, 7'h15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 19'h15123, 8'hFF, 4'd3},  // R3 sprite fill
    '{2'd0, 16'h2007, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd5},  // R5 zero byte
    '{2'd1, 16'h2100, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 19'h0,     8'h00, 4'd5},  // R5 ordinary
    '{2'd0, 16'h2127, 8'h00, 7'h15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd4},  // R4 capture 12
    '{2'd1, 16'h2400, 8'h00, 7'h15, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 19'h0,     8'h00, 4'd4},  // R4 gated
    '{2'd1, 16'h3124, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 19'h0,     8'h00, 4'd6},  // R6 cleared by R4
    '{2'd0, 16'h2347, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd9},  // R9 capture 34
    '{2'd0, 16'h2AB6, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd9},  // R9 nibble 6
    '{2'd0, 16'h4567, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd9},  // R9 outside
    '{2'd1, 16'h2800, 8'h00, 7'h15, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 19'h00400, 8'h34, 4'd9},  // R9/R2 horiz
    '{2'd2, 16'h1ABC, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 19'h15ABC, 8'h00, 4'd7},  // R7 read
    '{2'd1, 16'h1ABC, 8'h5A, 7'h15, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 19'h15ABC, 8'h5A, 4'd7},  // R7 write
    '{2'd1, 16'h3F10, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd10}, // R10 palette
    '{2'd2, 16'h0800, 8'h00, 7'h15, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd10}, // R10 playfield
    '{2'd0, 16'h3557, 8'h00, 7'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd11}, // R11 first
    '{2'd0, 16'h3667, 8'h00, 7'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd11}, // R11 second
    '{2'd1, 16'h3001, 8'h00, 7'h7F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 19'h7F001, 8'h66, 4'd11}, // R11 newest
    '{2'd0, 16'h2777, 8'h00, 7'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 19'h0,     8'h00, 4'd7},  // R7 capture
    '{2'd1, 16'h1001, 8'h99, 7'h7F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 19'h7F001, 8'h99, 4'd7},  // R7 port wins
    '{2'd1, 16'h2001, 8'h00, 7'h7F, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 19'h0,     8'h00, 4'd6}   // R6 cleared
  };

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_wr = 1'b0; ppu_wr = 1'b0; ppu_rd = 1'b0;
  endtask

  task automatic check_out(input string tag, input logic ewe, input logic eoe, input logic ece,
                           input logic [18:0] eaddr, input logic [7:0] edat);
    cmp({tag, " we"}, 32'(gram_we), 32'(ewe));
    cmp({tag, " oe"}, 32'(gram_oe), 32'(eoe));
    cmp({tag, " ntce"}, 32'(ntram_ce), 32'(ece));
    if (ewe || eoe) cmp({tag, " addr"}, 32'(gram_addr), 32'(eaddr));
    if (ewe) cmp({tag, " data"}, 32'(gram_wdata), 32'(edat));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    #1 check_out("R1 in reset", 1'b0, 1'b0, 1'b0, 19'h0, 8'h0);
    @(negedge clk); rst_n = 1'b1;
    // R1: no fill pending after reset
    ppu_wr = 1'b1; ppu_addr = 14'h2000;
    #1 check_out("R1 first write", 1'b0, 1'b0, 1'b1, 19'h0, 8'h0);
    @(negedge clk); idle();
    #1 check_out("R1 idle", 1'b0, 1'b0, 1'b0, 19'h0, 8'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      spr_bank = VECS[i].bank; nt_mirror_h = VECS[i].mir; fill_gram_en = VECS[i].fen;
      ppu_wdata = VECS[i].wd;
      if (VECS[i].kind == 2'd0) cpu_addr = VECS[i].addr;
      else ppu_addr = VECS[i].addr[13:0];
      cpu_wr = (VECS[i].kind == 2'd0);
      ppu_wr = (VECS[i].kind == 2'd1);
      ppu_rd = (VECS[i].kind == 2'd2);
      #1 check_out($sformatf("R%0d vec%0d", VECS[i].req, i),
                   VECS[i].ewe, VECS[i].eoe, VECS[i].ece, VECS[i].eaddr, VECS[i].edat);
    end
    @(negedge clk); idle();
    spr_bank = 7'h15; nt_mirror_h = 1'b0; fill_gram_en = 1'b1;

    // R8: capture and video write in the same cycle
    cpu_wr = 1'b1; cpu_addr = 16'h2117;
    @(negedge clk);
    cpu_addr = 16'h2227; ppu_wr = 1'b1; ppu_addr = 14'h2005;
    #1 check_out("R8 old byte", 1'b1, 1'b0, 1'b1, 19'h00005, 8'h11);
    @(negedge clk); cpu_wr = 1'b0; ppu_addr = 14'h2006;
    #1 check_out("R8 new byte", 1'b1, 1'b0, 1'b1, 19'h00006, 8'h22);

    // R1: reset drops a pending fill
    @(negedge clk); idle(); cpu_wr = 1'b1; cpu_addr = 16'h2EE7;
    @(negedge clk); idle(); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); ppu_wr = 1'b1; ppu_addr = 14'h2010;
    #1 check_out("R1 reset clears", 1'b0, 1'b0, 1'b1, 19'h0, 8'h0);
    @(negedge clk); idle();
    @(negedge clk);
    finish_run();
  end
endmodule